// File: doc/BRIEF.md
# Buffered Serial Transmitter with Clear-to-Send Gating

This block turns bytes into asynchronous serial frames on a single output line. Bytes arrive through a write port and wait in a small FIFO. A frame sequencer takes them one at a time and shifts them out, one bit per pulse of an external baud tick. The line format is set at runtime by a few control inputs: the number of data bits, one or two stop bits, and no, even or odd parity. The sequencer captures these settings when a frame begins.

Two controls act on the line itself. A break input forces the line low for as long as it is set. When flow control is enabled, a clear-to-send input decides whether the next frame may begin. It is checked only at frame boundaries, so a frame that has started always finishes. A FIFO-enable input reduces the buffer to a single holding slot. A busy output tells the host when every queued byte has fully left the line.

Top module: `uart_tx_fc`

## Requirements
- R1: The line idles high. Each frame is one low start bit, then the data bits LSB first, then optional parity, then high stop bits. The line changes only in the cycle after a baud tick, so each bit lasts one tick interval.
- R2: The 2-bit word-length input `wlen` encodes the number of data bits minus five: 0 means 5 bits, 1 means 6, 2 means 7 and 3 means 8. Only the low bits of the queued byte are sent.
- R3: With `par_en` low no parity bit is sent. With `par_en` high, a parity bit follows the data. Its value is chosen over the active data bits only: the total count of ones is even when `par_even` is 1 and odd when `par_even` is 0.
- R4: With `two_stop` low a frame ends with one high stop bit. With `two_stop` high it ends with two.
- R5: While `brk` is high, `txd` is low in every cycle. After `brk` clears, the line shows the sequencer's level again, which is high when the sequencer is idle.
- R6: With the FIFO enabled, it holds 16 bytes. `full` is high exactly when 16 bytes are held. A write presented while `full` is high is dropped and never transmitted.
- R7: `busy` is high from the first accepted write until the final stop bit of the last queued byte has ended. It falls in the cycle after the tick that ends that stop bit.
- R8: With `fifo_en` low the buffer holds one byte. `full` rises once one byte is held, and a second write is dropped.
- R9: With `flow_en` high and `cts` low, no new frame starts and the line stays high. A frame already under way completes. With `flow_en` low, `cts` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to queue |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| cts | input | 1 | Clear-to-send, high permits a new frame |
| flow_en | input | 1 | Enables clear-to-send gating |
| fifo_en | input | 1 | 1: 16-entry FIFO, 0: single holding slot |
| wlen | input | 2 | Data bits minus five |
| two_stop | input | 1 | Selects two stop bits |
| par_en | input | 1 | Enables the parity bit |
| par_even | input | 1 | Even parity when set, odd when clear |
| brk | input | 1 | Holds the line low |
| txd | output | 1 | Serial output line |
| busy | output | 1 | Data queued or frame in progress |
| full | output | 1 | Buffer at capacity, writes dropped |

## Verification
A corrupted FIFO pointer or count shows up at the next frame as a wrong or repeated byte on the line. It can also show up as `full` rising at the wrong fill level, and it is seen within one frame time of the error. A sequencer that miscounts data or stop bits shifts every later bit of the frame. The bench receiver sees this as a data or parity mismatch at the end of that same frame, and the `busy` edge moves by one tick. A wrong gating decision shows within a single tick interval, as a start bit that appears while clear-to-send is low.

// File: rtl/uart_tx_fc.sv
module uart_tx_fc #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       baud_tick,
  input  logic       cts,
  input  logic       flow_en,
  input  logic       fifo_en,
  input  logic [1:0] wlen,
  input  logic       two_stop,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       brk,
  output logic       txd,
  output logic       busy,
  output logic       full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  localparam logic [2:0] S_IDLE  = 3'd0;
  localparam logic [2:0] S_START = 3'd1;
  localparam logic [2:0] S_DATA  = 3'd2;
  localparam logic [2:0] S_PAR   = 3'd3;
  localparam logic [2:0] S_STOP  = 3'd4;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  logic [2:0] st;
  logic [2:0] bit_cnt;
  logic       stop2;
  logic [7:0] shreg;
  logic [1:0] wlen_q;
  logic       two_q, par_en_q, par_q;
  logic       line;

  wire [CW-1:0] cap   = fifo_en ? CW'(DEPTH) : CW'(1);
  wire          empty = (cnt == '0);
  wire          push  = wr_en && !full;
  wire          start_ok  = !empty && (!flow_en || cts);
  wire          stop_last = !two_q || stop2;
  wire          load = baud_tick && start_ok &&
                       ((st == S_IDLE) || (st == S_STOP && stop_last));
  wire [7:0]    head   = mem[rp];
  wire [7:0]    masked = head & (8'hFF >> (2'd3 - wlen));
  wire          last_data = (bit_cnt == ({1'b0, wlen_q} + 3'd4));

  assign full = (cnt >= cap);
  assign busy = !empty || (st != S_IDLE);
  assign txd  = brk ? 1'b0 : line;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (load) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(load);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bit_cnt  <= '0;
      stop2    <= 1'b0;
      shreg    <= '0;
      wlen_q   <= '0;
      two_q    <= 1'b0;
      par_en_q <= 1'b0;
      par_q    <= 1'b0;
    end else if (load) begin
      st       <= S_START;
      shreg    <= head;
      wlen_q   <= wlen;
      two_q    <= two_stop;
      par_en_q <= par_en;
      par_q    <= (^masked) ^ ~par_even;
      bit_cnt  <= '0;
      stop2    <= 1'b0;
    end else if (baud_tick) begin
      case (st)
        S_START: begin
          st      <= S_DATA;
          bit_cnt <= '0;
        end
        S_DATA: begin
          shreg <= shreg >> 1;
          if (last_data) begin
            st    <= par_en_q ? S_PAR : S_STOP;
            stop2 <= 1'b0;
          end else begin
            bit_cnt <= bit_cnt + 3'd1;
          end
        end
        S_PAR: begin
          st    <= S_STOP;
          stop2 <= 1'b0;
        end
        S_STOP: begin
          if (stop_last) st <= S_IDLE;
          else           stop2 <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_START: line = 1'b0;
      S_DATA:  line = shreg[0];
      S_PAR:   line = par_q;
      default: line = 1'b1;
    endcase
  end
endmodule

// File: rtl/uart_tx_fc_chk.sv
module uart_tx_fc_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          baud_tick,
  input logic          cts,
  input logic          flow_en,
  input logic          fifo_en,
  input logic          brk,
  input logic          txd,
  input logic          full,
  input logic [2:0]    st,
  input logic [CW-1:0] cnt
);
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  assert_full_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !baud_tick) |=> cnt == $past(cnt));

  assert_single_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && cnt != '0) |-> full);

  assert_cts_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && flow_en && !cts) |=> st == 3'd0);

  assert_start_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd1 && !brk) |-> !txd);

  assert_tick_pace_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(st));
endmodule

bind uart_tx_fc uart_tx_fc_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cts(cts),
  .flow_en(flow_en), .fifo_en(fifo_en), .brk(brk), .txd(txd),
  .full(full), .st(st), .cnt(cnt)
);

// File: tb/tb_uart_tx_fc.sv
module tb_uart_tx_fc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       baud_tick = 1'b0;
  logic       cts = 1'b1;
  logic       flow_en = 1'b0;
  logic       fifo_en = 1'b1;
  logic [1:0] wlen = 2'd3;
  logic       two_stop = 1'b0;
  logic       par_en = 1'b0;
  logic       par_even = 1'b0;
  logic       brk = 1'b0;
  logic       txd, busy, full;

  uart_tx_fc dut (.*);

  always #4 clk = ~clk;

  int nvec = 0;
  int nerr = 0;
  logic [7:0] expq [$];

  int rx_phase = 0;
  int rx_idx = 0;
  int rx_stop = 0;
  int rx_frames = 0;
  logic [7:0] rx_byte = '0;
  logic rx_par = 1'b0;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fmask(input logic [1:0] w);
    return 8'hFF >> (2'd3 - w);
  endfunction

  function automatic logic exp_par(input logic [7:0] d, input logic [1:0] w, input logic ev);
    return (^(d & fmask(w))) ^ ~ev;
  endfunction

  initial begin
    int c = 0;
    forever begin
      @(posedge clk); #1;
      baud_tick = (c == 3);
      c = (c + 1) % 4;
    end
  end

  // bench receiver: samples the line at the end of each bit time
  always @(negedge clk) begin
    if (rst_n && baud_tick && !brk) begin
      case (rx_phase)
        0: if (txd == 1'b0) begin
             rx_phase = 1; rx_idx = 0; rx_byte = '0;
           end
        1: begin
             rx_byte[rx_idx] = txd;
             rx_idx++;
             if (rx_idx == int'(wlen) + 5) begin
               rx_phase = par_en ? 2 : 3;
               rx_stop = 0;
             end
           end
        2: begin rx_par = txd; rx_phase = 3; end
        default: begin
          check(txd == 1'b1, "R4 stop bit level", int'(txd), 1);
          rx_stop++;
          if (rx_stop == (two_stop ? 2 : 1)) begin
            logic [7:0] e;
            check(busy == 1'b1, "R7 busy through last stop", int'(busy), 1);
            if (expq.size() == 0) begin
              check(1'b0, "R6 unexpected frame", int'(rx_byte), 0);
            end else begin
              e = expq.pop_front();
              check(rx_byte == (e & fmask(wlen)), "R2 data bits", int'(rx_byte), int'(e & fmask(wlen)));
              if (par_en)
                check(rx_par == exp_par(e, wlen, par_even), "R3 parity bit",
                      int'(rx_par), int'(exp_par(e, wlen, par_even)));
            end
            rx_frames++;
            rx_phase = 0;
          end
        end
      endcase
    end
  end

  task automatic wr(input logic [7:0] b, output logic acc);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    acc = !full;
    if (acc) expq.push_back(b);
  endtask

  task automatic wr_end();
    @(posedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    @(negedge clk);
    while ((busy || expq.size() != 0 || rx_phase != 0) && n < 20000) begin
      @(negedge clk); n++;
    end
    check(n < 20000, "R7 drain completes", n, 0);
  endtask

  task automatic set_fmt(input logic [1:0] w, input logic ts, input logic pe, input logic ev);
    @(posedge clk); #1;
    wlen = w; two_stop = ts; par_en = pe; par_even = ev;
  endtask

  initial begin
    #(8 * 150000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic acc;
    int f0, nacc;
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(txd == 1'b1, "R1 idle line high", int'(txd), 1);
    check(busy == 1'b0, "R7 not busy after reset", int'(busy), 0);
    check(full == 1'b0, "R6 not full after reset", int'(full), 0);

    // R6 capacity with transmission held off (R9)
    flow_en = 1'b1; cts = 1'b0;
    nacc = 0;
    for (int i = 0; i < 20; i++) begin
      wr(8'(8'h30 + i), acc);
      if (acc) nacc++;
    end
    wr_end();
    check(nacc == 16, "R6 accepted count", nacc, 16);
    @(negedge clk);
    check(full == 1'b1, "R6 full at 16", int'(full), 1);
    repeat (40) begin
      @(negedge clk);
      check(txd == 1'b1, "R9 no start while cts low", int'(txd), 1);
    end
    f0 = rx_frames;
    @(posedge clk); #1 cts = 1'b1;
    drain();
    check(rx_frames - f0 == 16, "R6 sixteen frames", rx_frames - f0, 16);

    // R8 single slot
    @(posedge clk); #1 cts = 1'b0; fifo_en = 1'b0;
    wr(8'hA5, acc);
    wr(8'h5A, acc);
    wr_end();
    check(acc == 1'b0, "R8 second write dropped", int'(acc), 0);
    @(negedge clk);
    check(full == 1'b1, "R8 full with one byte", int'(full), 1);
    f0 = rx_frames;
    @(posedge clk); #1 cts = 1'b1;
    drain();
    check(rx_frames - f0 == 1, "R8 one frame only", rx_frames - f0, 1);
    @(posedge clk); #1 fifo_en = 1'b1;

    // R9 frame in flight completes, next one held
    f0 = rx_frames;
    set_fmt(2'd2, 1'b0, 1'b1, 1'b1);
    wr(8'h6C, acc);
    wr(8'h13, acc);
    wr_end();
    wait (rx_phase != 0);
    @(posedge clk); #1 cts = 1'b0;
    wait (rx_frames == f0 + 1);
    repeat (60) @(negedge clk);
    check(rx_frames == f0 + 1, "R9 held after current frame", rx_frames - f0, 1);
    check(busy == 1'b1, "R7 busy while byte held", int'(busy), 1);
    check(txd == 1'b1, "R9 line idle while held", int'(txd), 1);
    @(posedge clk); #1 cts = 1'b1;
    drain();
    check(rx_frames == f0 + 2, "R9 release sends held byte", rx_frames - f0, 2);

    // R9 flow control disabled ignores cts
    @(posedge clk); #1 flow_en = 1'b0; cts = 1'b0;
    f0 = rx_frames;
    wr(8'hC3, acc);
    wr_end();
    drain();
    check(rx_frames == f0 + 1, "R9 cts ignored when disabled", rx_frames - f0, 1);

    // R4/R7 two stop bits: busy falls right after second stop
    set_fmt(2'd0, 1'b1, 1'b1, 1'b0);
    f0 = rx_frames;
    wr(8'h1F, acc);
    wr_end();
    wait (rx_frames == f0 + 1);
    @(negedge clk);
    check(busy == 1'b0, "R7 busy falls after final stop", int'(busy), 0);

    // R5 break
    @(posedge clk); #1 brk = 1'b1;
    repeat (12) begin
      @(negedge clk);
      check(txd == 1'b0, "R5 break holds low", int'(txd), 0);
    end
    @(posedge clk); #1 brk = 1'b0;
    @(negedge clk);
    check(txd == 1'b1, "R5 release returns high", int'(txd), 1);

    // random formats and traffic
    for (int g = 0; g < 12; g++) begin
      int nb;
      set_fmt(2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
      @(posedge clk); #1 flow_en = 1'($urandom % 2); cts = 1'b1;
      nb = 4 + ($urandom % 14);
      for (int k = 0; k < nb; k++) begin
        wr(8'($urandom), acc);
        if (($urandom % 4) == 0) begin
          wr_end();
          @(posedge clk); #1 cts = 1'($urandom % 2);
          repeat ($urandom % 30) @(posedge clk);
        end
      end
      wr_end();
      @(posedge clk); #1 cts = 1'b1;
      drain();
    end

    check(expq.size() == 0, "R2 all bytes received", expq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule